// File: doc/BRIEF.md
# Gated Oscillator Frequency-Ratio Counter

This block measures how fast one of six sensing oscillators runs compared with a reference clock. Software or a sequencer raises `senseEn`. The window generator then opens a gate that lasts exactly `WINDOW` reference cycles. While the gate is open, each rising edge of the selected oscillator adds one to a 12-bit result. When the gate closes, the result is `WINDOW × f_osc / f_ref`, which is a frequency ratio taken over a fixed interval.

A 3-bit range code picks the oscillator. The code feeds a decoder that drives one enable line per oscillator, and the same code steers a multiplexer that routes that oscillator to the counter. The code is captured while the block is idle and is held for the whole window. The oscillator inputs are sampled in the reference domain through a synchronizer, so each must run below half the reference frequency. A separate clear input empties the result before each measurement. At the end of the window a one-cycle done pulse appears, and the result then stays frozen until the next clear.

Top module: `osc_ratio_counter`

## Requirements
- R1: A rising edge of `senseEn`, sampled at a reference clock edge while idle and with `ctrClr` low, raises `gateOut` from that edge, and `gateOut` stays high for exactly `WINDOW` reference cycles (default 8192).
- R2: While `gateOut` is high, every rising edge of the selected oscillator adds exactly one to `countOut`. For an oscillator whose period is an integer number of reference cycles dividing `WINDOW`, the final count is `WINDOW × f_osc / f_ref`.
- R3: `countOut` saturates at 4095 and never wraps to a lower value.
- R4: `rangeSel` values 0 to 5 select oscillator input `oscIn[rangeSel]`. While `gateOut` is high, `oscEn` equals `1 << rangeSel`. While `gateOut` is low, `oscEn` is all zeros.
- R5: `rangeSel` values 6 and 7 drive no bit of `oscEn`, and the measurement gives a count of 0.
- R6: `doneOut` is high for exactly one cycle, in the cycle after the last gated cycle, and only when the window runs to its full length. From then on `countOut` holds its value until `ctrClr`.
- R7: `ctrClr` high at a clock edge sets `countOut` to 0, drops `doneOut` and closes any open gate.
- R8: If `senseEn` goes low while the gate is open, the gate closes at the next edge, no done pulse follows, and the partial count is held.
- R9: After reset, `countOut` is 0 and `gateOut`, `doneOut` and `oscEn` are all low.
- R10: Keeping `senseEn` high after a window has ended does not open a second window. A new window needs `senseEn` to go low and then high again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| senseEn | input | 1 | Sensing enable; its rising edge starts a window and its low level aborts one |
| ctrClr | input | 1 | Synchronous clear of the result |
| rangeSel | input | 3 | Supply-range code that selects the oscillator |
| oscIn | input | 6 | Oscillator inputs, one per supply range |
| gateOut | output | 1 | High during the counting window |
| doneOut | output | 1 | One-cycle pulse when a full window closes |
| oscEn | output | 6 | One-hot enable to the selected oscillator during the window |
| countOut | output | 12 | Saturating count of gated oscillator edges |

## Verification
A fault in the window counter shows up as a gate that is one or more cycles off `WINDOW`, and as a count that is off by a whole number of oscillator periods. Both are visible when `doneOut` appears, about 8200 cycles after the start. A wrong decoder or multiplexer state gives a wrong `oscEn` pattern in the first gated cycle, and a count that matches a different oscillator's period. A fault in the saturation or hold logic appears either as a wrapped value at the end of a fast window or as a count that moves during the idle cycles after done.

// File: rtl/osc_ratio_pkg.sv
package osc_ratio_pkg;

  // Strobes from the window control to the counting datapath
  typedef struct packed {
    logic gate;   // counting window open
    logic clear;  // empty the result
  } ctrlStrobeT;

endpackage

// File: rtl/osc_ratio_ctrl.sv
module osc_ratio_ctrl
  import osc_ratio_pkg::*;
#(
  parameter int WINDOW = 8192
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       senseEn,
  input  logic       ctrClr,
  output ctrlStrobeT strobe,
  output logic       doneOut
);

  localparam int WIN_W = (WINDOW > 2) ? $clog2(WINDOW) : 1;

  logic             gateQ;
  logic             enQ;
  logic [WIN_W-1:0] winLeft;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gateQ   <= 1'b0;
      enQ     <= 1'b0;
      doneOut <= 1'b0;
      winLeft <= '0;
    end else begin
      enQ     <= senseEn;
      doneOut <= 1'b0;
      if (ctrClr) begin
        gateQ <= 1'b0;
      end else if (gateQ) begin
        if (!senseEn) begin
          gateQ <= 1'b0;                 // aborted window, no done
        end else if (winLeft == '0) begin
          gateQ   <= 1'b0;
          doneOut <= 1'b1;
        end else begin
          winLeft <= winLeft - 1'b1;
        end
      end else if (senseEn && !enQ) begin
        gateQ   <= 1'b1;
        winLeft <= WIN_W'(WINDOW - 1);
      end
    end
  end

  always_comb begin
    strobe.gate  = gateQ;
    strobe.clear = ctrClr;
  end

endmodule

// File: rtl/osc_ratio_datapath.sv
module osc_ratio_datapath
  import osc_ratio_pkg::*;
#(
  parameter int NUM_OSC     = 6,
  parameter int CODE_W      = 3,
  parameter int CNT_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobeT         strobe,
  input  logic [CODE_W-1:0]  rangeSel,
  input  logic [NUM_OSC-1:0] oscIn,
  output logic [NUM_OSC-1:0] oscEn,
  output logic [CNT_W-1:0]   countOut
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam int PIPE_W = SYNC_STAGES + 1;

  logic [CODE_W-1:0]  rangeLat;
  logic [NUM_OSC-1:0] decoded;
  logic               oscPick;
  logic [PIPE_W-1:0]  syncPipe;
  logic               oscRise;

  // Range code follows the input while idle and is frozen for the window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             rangeLat <= '0;
    else if (!strobe.gate) rangeLat <= rangeSel;
  end

  // One decoder line per oscillator; codes past the last give none
  for (genvar i = 0; i < NUM_OSC; i++) begin : g_dec
    assign decoded[i] = (rangeLat == CODE_W'(i));
  end

  assign oscPick = |(oscIn & decoded);
  assign oscEn   = strobe.gate ? decoded : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncPipe <= '0;
    else       syncPipe <= {syncPipe[PIPE_W-2:0], oscPick};
  end

  assign oscRise = syncPipe[PIPE_W-2] & ~syncPipe[PIPE_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                   countOut <= '0;
    else if (strobe.clear)                       countOut <= '0;
    else if (strobe.gate && oscRise && countOut != CNT_MAX)
                                                 countOut <= countOut + 1'b1;
  end

endmodule

// File: rtl/osc_ratio_counter.sv
module osc_ratio_counter
  import osc_ratio_pkg::*;
#(
  parameter int NUM_OSC = 6,
  parameter int CODE_W  = 3,
  parameter int CNT_W   = 12,
  parameter int WINDOW  = 8192
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               senseEn,
  input  logic               ctrClr,
  input  logic [CODE_W-1:0]  rangeSel,
  input  logic [NUM_OSC-1:0] oscIn,
  output logic               gateOut,
  output logic               doneOut,
  output logic [NUM_OSC-1:0] oscEn,
  output logic [CNT_W-1:0]   countOut
);

  ctrlStrobeT strobe;

  osc_ratio_ctrl #(.WINDOW(WINDOW)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .senseEn (senseEn),
    .ctrClr  (ctrClr),
    .strobe  (strobe),
    .doneOut (doneOut)
  );

  osc_ratio_datapath #(
    .NUM_OSC     (NUM_OSC),
    .CODE_W      (CODE_W),
    .CNT_W       (CNT_W),
    .SYNC_STAGES (2)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .rangeSel (rangeSel),
    .oscIn    (oscIn),
    .oscEn    (oscEn),
    .countOut (countOut)
  );

  assign gateOut = strobe.gate;

endmodule

// File: rtl/osc_ratio_checker.sv
module osc_ratio_checker #(
  parameter int NUM_OSC = 6,
  parameter int CNT_W   = 12,
  parameter int WINDOW  = 8192
) (
  input logic               clk,
  input logic               rstN,
  input logic               senseEn,
  input logic               ctrClr,
  input logic               gateOut,
  input logic               doneOut,
  input logic [NUM_OSC-1:0] oscEn,
  input logic [CNT_W-1:0]   countOut
);

  localparam int RUN_W = $clog2(WINDOW + 2) + 1;
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic [RUN_W-1:0] runLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        runLen <= '0;
    else if (gateOut) runLen <= runLen + 1'b1;
    else              runLen <= '0;
  end

  p_gate_len_r1: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> (runLen == RUN_W'(WINDOW)));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    (countOut == CMAX && !ctrClr) |=> (countOut == CMAX));

  p_onehot_en_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(oscEn));

  p_idle_en_r4: assert property (@(posedge clk) disable iff (!rstN)
    !gateOut |-> (oscEn == '0));

  p_invalid_still_r5: assert property (@(posedge clk) disable iff (!rstN)
    (gateOut && $past(gateOut, 3) && oscEn == '0 && !ctrClr) |=> $stable(countOut));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!gateOut && !ctrClr) |=> $stable(countOut));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctrClr |=> (countOut == '0 && !doneOut && !gateOut));

  p_abort_r8: assert property (@(posedge clk) disable iff (!rstN)
    (gateOut && !senseEn) |=> (!gateOut && !doneOut));

endmodule

bind osc_ratio_counter osc_ratio_checker #(
  .NUM_OSC (NUM_OSC),
  .CNT_W   (CNT_W),
  .WINDOW  (WINDOW)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .senseEn  (senseEn),
  .ctrClr   (ctrClr),
  .gateOut  (gateOut),
  .doneOut  (doneOut),
  .oscEn    (oscEn),
  .countOut (countOut)
);

// File: tb/tb_osc_ratio_counter.sv
`timescale 1ns/1ps
module tb_osc_ratio_counter;

  localparam int WIN = 8192;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       senseEn = 1'b0;
  logic       ctrClr = 1'b0;
  logic [2:0] rangeSel = 3'd0;
  logic [5:0] oscIn;
  logic       gateOut, doneOut;
  logic [5:0] oscEn;
  logic [11:0] countOut;

  int total = 0;
  int passed = 0;

  always #5 clk = ~clk;

  // Half periods in ns; all edges land at 2 mod 5 ns, away from clock edges
  function automatic int halfPer(int i);
    case (i)
      0: return 20;   // 40 ns  -> 4 ref cycles
      1: return 10;   // 20 ns  -> 2 ref cycles
      2: return 80;   // 160 ns -> 16 ref cycles
      3: return 40;   // 80 ns  -> 8 ref cycles
      4: return 30;   // 60 ns
      default: return 15; // 30 ns -> 3 ref cycles
    endcase
  endfunction

  for (genvar g = 0; g < 6; g++) begin : g_osc
    initial begin
      oscIn[g] = 1'b0;
      #2;
      forever #(halfPer(g)) oscIn[g] = ~oscIn[g];
    end
  end

  osc_ratio_counter dut (
    .clk(clk), .rstN(rstN), .senseEn(senseEn), .ctrClr(ctrClr),
    .rangeSel(rangeSel), .oscIn(oscIn), .gateOut(gateOut),
    .doneOut(doneOut), .oscEn(oscEn), .countOut(countOut)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (ok) passed++;
    else $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
  endtask

  task automatic clearCount();
    @(negedge clk) ctrClr = 1'b1;
    @(negedge clk) ctrClr = 1'b0;
  endtask

  // One full window on a given code; checks gate length, enables, count, done
  task automatic measure(input int code, input int expCnt, input int tol,
                         input string req);
    int gateCyc = 0;
    int enBad = 0;
    int doneSeen = 0;
    int held;
    int expEn = (code < 6) ? (1 << code) : 0;
    @(negedge clk) rangeSel = 3'(code);
    repeat (6) @(negedge clk);
    clearCount();
    chk(countOut == 0, "R7", "count after clear", countOut, 0);
    @(negedge clk) senseEn = 1'b1;
    for (int t = 0; t < WIN + 50; t++) begin
      @(negedge clk);
      if (gateOut) begin
        gateCyc++;
        if (oscEn != 6'(expEn)) enBad++;
      end
      if (doneOut) begin
        doneSeen = 1;
        break;
      end
    end
    chk(gateCyc == WIN, "R1", "gate length", gateCyc, WIN);
    chk(enBad == 0, (code < 6) ? "R4" : "R5", "oscEn mismatches", enBad, 0);
    chk(doneSeen == 1, "R6", "done seen", doneSeen, 1);
    chk(countOut >= expCnt - tol && countOut <= expCnt + tol, req,
        "window count", countOut, expCnt);
    held = countOut;
    @(negedge clk);
    chk(doneOut == 1'b0, "R6", "done width", doneOut, 0);
    // R10: enable still high, no new window may open
    begin
      int reopen = 0;
      for (int t = 0; t < 30; t++) begin
        @(negedge clk);
        if (gateOut) reopen++;
      end
      chk(reopen == 0, "R10", "gate cycles with enable held", reopen, 0);
    end
    chk(countOut == held, "R6", "count held after done", countOut, held);
    chk(oscEn == 0, "R4", "oscEn idle", oscEn, 0);
    @(negedge clk) senseEn = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic testReset();
    chk(countOut == 0, "R9", "reset count", countOut, 0);
    chk(gateOut == 0, "R9", "reset gate", gateOut, 0);
    chk(doneOut == 0, "R9", "reset done", doneOut, 0);
    chk(oscEn == 0, "R9", "reset oscEn", oscEn, 0);
  endtask

  task automatic testAbort();
    int held;
    int lateDone = 0;
    @(negedge clk) rangeSel = 3'd0;
    repeat (6) @(negedge clk);
    clearCount();
    @(negedge clk) senseEn = 1'b1;
    repeat (400) @(negedge clk);
    chk(gateOut == 1'b1, "R8", "gate open mid window", gateOut, 1);
    senseEn = 1'b0;
    @(negedge clk);
    chk(gateOut == 1'b0, "R8", "gate after abort", gateOut, 0);
    held = countOut;
    chk(held > 90 && held < 110, "R8", "partial count", held, 100);
    for (int t = 0; t < 40; t++) begin
      @(negedge clk);
      if (doneOut) lateDone++;
    end
    chk(lateDone == 0, "R8", "done after abort", lateDone, 0);
    chk(countOut == held, "R8", "partial count held", countOut, held);
    clearCount();
    chk(countOut == 0, "R7", "clear after abort", countOut, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    measure(0, 2048, 0, "R2");   // period 4 cycles
    measure(3, 1024, 0, "R2");   // period 8 cycles
    measure(2, 512, 0, "R4");    // period 16 cycles, checks routing
    measure(5, 2731, 1, "R2");   // period 3 cycles, ratio not integral
    measure(1, 4095, 0, "R3");   // 4096 edges, must saturate
    measure(6, 0, 0, "R5");      // unused code
    testAbort();
    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end

endmodule